// File: doc/BRIEF.md
# Bit-Pipelined Ripple-Carry Adder

This block adds two WIDTH-bit operands and a carry-in. The carry chain is cut by a flip-flop after every bit position, so the longest combinational path is one full-adder cell. A new operand pair can be accepted on every clock cycle. The input side delays operand bit i by i register stages, so that each bit reaches its adder cell in the same cycle as the registered carry from the cell below. The output side delays the sum bit of cell i by WIDTH-i stages, so that the whole sum word and the final carry leave together.

A valid flag travels through a WIDTH-stage shift register beside the data. Each result therefore appears exactly WIDTH cycles after its operands were taken. The reset is asynchronous and active low, and it clears only the valid pipeline. The data registers are not reset, because a stale value is never marked valid. The upstream logic is expected to release the reset synchronously to the clock.

Top module: `psa_pipe_adder`

## Requirements
- R1: When out_valid is 1, out_sum equals the low WIDTH bits of in_a + in_b + in_cin, where in_a, in_b and in_cin are the values sampled with in_valid = 1 exactly WIDTH clock edges earlier.
- R2: When out_valid is 1, out_cout equals bit WIDTH of that same sum, which is the carry out of the top bit.
- R3: out_valid equals in_valid delayed by exactly WIDTH rising clock edges. No result appears earlier or later than that.
- R4: Operand pairs that enter on consecutive cycles give independent results. A long carry in one addition does not change the result of the addition before it or after it.
- R5: A cycle in which in_valid is 0 produces a cycle, WIDTH edges later, in which out_valid is 0.
- R6: While rst_n is 0, out_valid is 0. After rst_n returns to 1, no result that entered before the reset is ever reported as valid.
- R7: A carry that ripples through all WIDTH bit positions is propagated correctly. For example, all-ones plus zero with carry-in 1 gives sum 0 and carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the valid pipeline |
| in_valid | input | 1 | Marks the operands on this cycle as a valid addition |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| in_cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | Marks out_sum and out_cout as a valid result |
| out_sum | output | WIDTH | Sum word, with all bits aligned |
| out_cout | output | 1 | Carry out of the top bit, aligned with out_sum |

## Verification
The bench uses directed operands that make a carry ripple through every bit position: all-ones plus one, all-ones plus all-ones, and complementary alternating patterns with and without carry-in. It also uses a lone top-bit carry. Together these separate a broken carry register or a wrong skew depth from a correct chain. A pair with a full-length ripple is alternated on consecutive cycles with a pair that has no carry at all, which exposes any leak between neighbouring carry slots. Random operands with random gaps in in_valid then check the sum, the carry and the exact latency of the valid flag. A reset applied while the pipeline is full shows that results already in flight are discarded.

// File: rtl/psa_pkg.sv
package psa_pkg;

  // Sum output of one full-adder cell.
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // Carry output of one full-adder cell: the majority of the three inputs.
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (y & ci) | (x & ci);
  endfunction

endpackage

// File: rtl/psa_skew.sv
// Shift register without reset, used for operand skew and sum deskew.
module psa_skew #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe_q [DEPTH];
  logic [WIDTH-1:0] pipe_d [DEPTH];

  always_comb begin
    pipe_d[0] = d;
    for (int k = 1; k < DEPTH; k++) begin
      pipe_d[k] = pipe_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    pipe_q <= pipe_d;
  end

  assign q = pipe_q[DEPTH-1];

endmodule

// File: rtl/psa_bit_stage.sv
// One bit position: a combinational full-adder cell followed by its carry flip-flop.
module psa_bit_stage
  import psa_pkg::*;
(
  input  logic clk,
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co_q
);

  logic co_d;

  always_comb begin
    s    = fa_sum(x, y, ci);
    co_d = fa_carry(x, y, ci);
  end

  always_ff @(posedge clk) begin
    co_q <= co_d;
  end

endmodule

// File: rtl/psa_pipe_adder.sv
module psa_pipe_adder #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             in_cin,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_cout
);

  localparam int LAT = WIDTH;

  logic [WIDTH-1:0] carry_q;
  logic [WIDTH-1:0] sum_raw;
  logic [LAT-1:0]   vld_q;
  logic [LAT-1:0]   vld_d;

  // Bit positions: skew on the inputs, adder cell, deskew on the sum
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic xa, yb, ci;

    if (i == 0) begin : g_first
      assign xa = in_a[0];
      assign yb = in_b[0];
      assign ci = in_cin;
    end else begin : g_rest
      logic [1:0] ab_dly;
      psa_skew #(.WIDTH(2), .DEPTH(i)) u_skew (
        .clk (clk),
        .d   ({in_a[i], in_b[i]}),
        .q   (ab_dly)
      );
      assign xa = ab_dly[1];
      assign yb = ab_dly[0];
      assign ci = carry_q[i-1];
    end

    psa_bit_stage u_stage (
      .clk  (clk),
      .x    (xa),
      .y    (yb),
      .ci   (ci),
      .s    (sum_raw[i]),
      .co_q (carry_q[i])
    );

    psa_skew #(.WIDTH(1), .DEPTH(WIDTH - i)) u_deskew (
      .clk (clk),
      .d   (sum_raw[i]),
      .q   (out_sum[i])
    );
  end

  assign out_cout = carry_q[WIDTH-1];

  // Valid pipeline: next-state process and register process
  always_comb begin
    vld_d = {vld_q[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign out_valid = vld_q[LAT-1];

endmodule

// File: rtl/psa_pipe_adder_chk.sv
module psa_pipe_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_a0,
  input logic             in_b0,
  input logic             in_cin,
  input logic             out_valid,
  input logic [WIDTH-1:0] carry_q
);

  localparam int CW = $clog2(WIDTH + 1) + 1;

  logic [CW-1:0] since_rst;
  logic [CW-1:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      inflight  <= '0;
    end else begin
      if (since_rst < CW'(WIDTH)) since_rst <= since_rst + 1'b1;
      inflight <= inflight + CW'(in_valid) - CW'(out_valid);
    end
  end

  // R6: one edge after reset is seen low, no valid result is reported
  a_r6_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !out_valid);

  // R3: no result can come out before WIDTH edges have passed since reset
  a_r3_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < CW'(WIDTH)) |-> !out_valid);

  // R5: a valid output needs a matching accepted input still in flight
  a_r5_valid_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight != '0));

  // R5: the pipeline never holds more than WIDTH additions
  a_r5_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(WIDTH));

  // R2: the carry flip-flop of bit 0 takes the majority of the last sampled inputs
  a_r2_stage0_carry: assert property (@(posedge clk) disable iff (!rst_n)
    carry_q[0] == (($past(in_a0) & $past(in_b0)) | ($past(in_b0) & $past(in_cin)) |
                   ($past(in_a0) & $past(in_cin))));

endmodule

bind psa_pipe_adder psa_pipe_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_a0     (in_a[0]),
  .in_b0     (in_b[0]),
  .in_cin    (in_cin),
  .out_valid (out_valid),
  .carry_q   (carry_q)
);

// File: tb/tb_psa_pipe_adder.sv
module tb_psa_pipe_adder;

  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int HN = 2048;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_cin = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_sum;
  logic         out_cout;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int epoch = 0;

  logic         hv [HN];
  logic [W-1:0] ha [HN];
  logic [W-1:0] hb [HN];
  logic         hc [HN];
  string        ht [HN];

  psa_pipe_adder #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_cin(in_cin), .out_valid(out_valid), .out_sum(out_sum), .out_cout(out_cout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // Check the outputs, then drive one cycle of stimulus (at the falling edge)
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic c, input string tag);
    @(negedge clk);
    if (cyc - W >= epoch) begin
      int k = cyc - W;
      logic [W:0] r;
      chk(hv[k] ? "R3" : "R5", {{W{1'b0}}, out_valid}, {{W{1'b0}}, hv[k]});
      if (hv[k] && out_valid) begin
        r = ref_add(ha[k], hb[k], hc[k]);
        chk(ht[k], {1'b0, out_sum}, {1'b0, r[W-1:0]});
        chk("R2", {{W{1'b0}}, out_cout}, {{W{1'b0}}, r[W]});
      end
    end else begin
      chk("R6", {{W{1'b0}}, out_valid}, '0);
    end
    in_valid = v; in_a = a; in_b = b; in_cin = c;
    hv[cyc] = v; ha[cyc] = a; hb[cyc] = b; hc[cyc] = c; ht[cyc] = tag;
    cyc++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd20250611);
    // reset state (R6)
    repeat (3) @(negedge clk);
    chk("R6", {{W{1'b0}}, out_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    epoch = cyc;

    // directed corner cases: full-length ripples (R7) and the top carry (R2)
    step(1, 32'hFFFF_FFFF, 32'h0000_0000, 1, "R7");
    step(1, 32'h0000_0000, 32'hFFFF_FFFF, 1, "R7");
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R7");
    step(1, 32'h0000_0000, 32'h0000_0000, 0, "R1");
    step(1, 32'hAAAA_AAAA, 32'h5555_5555, 0, "R1");
    step(1, 32'hAAAA_AAAA, 32'h5555_5555, 1, "R7");
    step(1, 32'h8000_0000, 32'h8000_0000, 0, "R2");
    // back-to-back: a full ripple next to an addition with no carry (R4)
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 0) step(1, 32'hFFFF_FFFF, 32'h0000_0001, 0, "R4");
      else            step(1, 32'h0000_0000, 32'h0000_0000, 0, "R4");
    end
    step(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R5");

    // random operands with random gaps in in_valid (R1, R3, R5)
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, $urandom, $urandom, $urandom % 2, "R1");
    end

    // reset while the pipeline is full (R6)
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    chk("R6", {{W{1'b0}}, out_valid}, '0);
    repeat (2) @(negedge clk);
    chk("R6", {{W{1'b0}}, out_valid}, '0);
    rst_n = 1'b1;
    cyc = cyc + 4;
    epoch = cyc;
    for (int i = 0; i < W + 3; i++) step(0, $urandom, $urandom, 1, "R6");
    step(1, 32'hFFFF_FFFF, 32'h0000_0001, 0, "R7");
    step(1, 32'h1234_5678, 32'h8765_4321, 1, "R1");

    // drain
    for (int i = 0; i < W + 2; i++) step(0, '0, '0, 0, "R5");
    finish_run();
  end

endmodule